// File: doc/BRIEF.md
# Bus-Cycle Step Program Sequencer

This block runs short stored programs of bus steps on behalf of a processor core with a 16-bit data bus and 32-bit byte addresses. Each step pairs a bus code with a post-step action. The bus code selects one of these:

- a program fetch;
- an upper-word or lower-word read or write;
- a stack push or pop;
- a vector fetch;
- an interrupt-acknowledge cycle;
- a supervisor stack pointer fetch;
- a no-operation or idle wait.

The post-step action can bump the effective address or the program counter by 2, shift the prefetch queue, or end the program.

The step programs live in a small on-chip ROM. After reset the sequencer runs the start-up program by itself. Later programs are launched with `start` and an entry index. The block keeps these registers:

- a program counter;
- a two-word prefetch queue;
- user and supervisor stack pointers;
- an effective-address register;
- a 32-bit bus data register.

While the block is idle, the core can preload the effective-address register and the bus data register.

Memory is reached through a request/acknowledge port. A cycle stays posted until the active-low acknowledge is seen at a clock edge.

Top module: `bus_step_seq`

## Requirements
- R1: After reset the sequencer runs the ROM program at entry 0 with no `start` needed. That program loads the supervisor stack pointer from the words at byte addresses 0 and 2, upper half first. It loads the program counter and bus data register from the words at 4 and 6. It then makes two program fetches. At the end, the queue holds the words at PC and PC+2, PC is the vector plus 4, and the effective address is 6.
- R2: A bus cycle keeps `mem_req`, `mem_addr`, `mem_we` and `mem_upper` steady until `dtack_n` is low at a rising edge. Each bus step takes one clock more than the acknowledge latency.
- R3: The supervisor stack pointer fetch codes load the upper and lower halves of the supervisor stack pointer straight from `mem_rdata`.
- R4: Read and write codes address the effective-address register. The upper-word codes move bits 31:16 of the bus data register and raise `mem_upper`. The lower-word codes move bits 15:0 and keep `mem_upper` low.
- R5: A push writes at SP-2 and leaves SP-2. A pop reads at SP and leaves SP+2. SP is the supervisor stack pointer when `supervisor` is 1 and the user stack pointer when it is 0; the other pointer is untouched. The program at entry 8 runs read-upper, read-lower, push-lower, push-upper, no-op, idle, pop-upper, pop-lower, write-upper and write-lower. Each of the two reads and the upper write adds 2 to the effective address afterwards.
- R6: A program fetch reads at PC into queue entry 1 and adds 2 to PC. The advance action copies entry 1 into entry 0. The PC action adds a further 2. Entry 20 runs interrupt-acknowledge, fetch-with-advance, fetch-with-PC-bump, end.
- R7: A no-op step lasts 4 clocks and an idle step lasts 2 clocks, neither raising `mem_req`. Entry 28 is no-op, idle, end.
- R8: An end step makes no bus cycle, even when it encodes one (entry 6 encodes a write and entry 28's end encodes a read). It raises `done` for exactly one clock and then leaves the sequencer idle with `busy` low.
- R9: An interrupt-acknowledge step raises `mem_iack`, addresses the effective-address register and loads bits 15:0 of the bus data register. Bits 31:16 keep their preloaded value.
- R10: Vector-fetch codes read at the effective address and load the matching half of both the program counter and the bus data register. Entry 24 runs vector-upper (then EA+2), vector-lower, end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a program while idle |
| start_addr | input | 5 | ROM entry of the program to launch |
| supervisor | input | 1 | Selects the supervisor stack pointer for stack steps |
| ld_ea | input | 1 | Load effective address from `ld_val` while idle |
| ld_dat | input | 1 | Load bus data register from `ld_val` while idle |
| ld_val | input | 32 | Preload value |
| mem_req | output | 1 | Bus cycle request |
| mem_addr | output | 32 | Byte address of the cycle |
| mem_we | output | 1 | 1 for a write cycle |
| mem_upper | output | 1 | Upper-word qualifier |
| mem_iack | output | 1 | Interrupt-acknowledge qualifier |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| dtack_n | input | 1 | Active-low cycle acknowledge |
| busy | output | 1 | A program is running |
| done | output | 1 | One-clock pulse on the end step |
| pc | output | 32 | Program counter |
| ea | output | 32 | Effective-address register |
| bus_data | output | 32 | Bus data register |
| usp | output | 32 | User stack pointer |
| ssp | output | 32 | Supervisor stack pointer |
| pq0 | output | 16 | Prefetch queue entry 0 |
| pq1 | output | 16 | Prefetch queue entry 1 |

## Verification
The transfer program is swept over acknowledge latencies 0 to 3, with the supervisor flag alternating. This separates handshake timing faults, which change the clock count, from stack-selection faults, which move the push and pop addresses onto the wrong pointer. Wrap-around below a zero user stack pointer is included. The start-up, fetch, vector and wait-only programs are each run against a computed memory image. Their logged cycle addresses, qualifiers and final register values tell these apart:

- wrong half routing;
- a missing post-increment;
- a queue shift in the wrong order;
- a sentinel that leaks a bus cycle.

// File: rtl/bss_pkg.sv
package bss_pkg;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned DATA_W = 2 * WORD_W;

  typedef enum logic [3:0] {
    BC_NOP,
    BC_IDLE,
    BC_PFETCH,
    BC_WR_HI,
    BC_WR_LO,
    BC_RD_HI,
    BC_RD_LO,
    BC_PUSH_HI,
    BC_PUSH_LO,
    BC_POP_HI,
    BC_POP_LO,
    BC_VEC_HI,
    BC_VEC_LO,
    BC_IACK,
    BC_SSP_HI,
    BC_SSP_LO
  } bus_code_e;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_EA2,
    ACT_PC2,
    ACT_ADVQ,
    ACT_END
  } step_act_e;

  typedef struct packed {
    bus_code_e code;
    step_act_e act;
  } step_t;

  // ROM entry points of the stored programs
  localparam int unsigned PRG_BOOT = 0;
  localparam int unsigned PRG_XFER = 8;
  localparam int unsigned PRG_MISC = 20;
  localparam int unsigned PRG_VEC  = 24;
  localparam int unsigned PRG_WAIT = 28;

  function automatic logic code_is_upper(bus_code_e c);
    return (c == BC_WR_HI) || (c == BC_RD_HI) || (c == BC_PUSH_HI) ||
           (c == BC_POP_HI) || (c == BC_VEC_HI) || (c == BC_SSP_HI);
  endfunction

  function automatic logic code_is_wait(bus_code_e c);
    return (c == BC_NOP) || (c == BC_IDLE);
  endfunction

  function automatic step_t mk_step(bus_code_e c, step_act_e a);
    step_t s;
    s.code = c;
    s.act  = a;
    return s;
  endfunction

endpackage

// File: rtl/bss_rst_sync.sv
module bss_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/bss_step_rom.sv
module bss_step_rom
  import bss_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] addr,
  output step_t         step
);

  always_comb begin
    case (int'(addr))
      // start-up program
      0:  step = mk_step(BC_SSP_HI,  ACT_EA2);
      1:  step = mk_step(BC_SSP_LO,  ACT_EA2);
      2:  step = mk_step(BC_VEC_HI,  ACT_EA2);
      3:  step = mk_step(BC_VEC_LO,  ACT_NONE);
      4:  step = mk_step(BC_PFETCH,  ACT_ADVQ);
      5:  step = mk_step(BC_PFETCH,  ACT_NONE);
      6:  step = mk_step(BC_WR_HI,   ACT_END);   // sentinel carries a write that must not happen
      // transfer program
      8:  step = mk_step(BC_RD_HI,   ACT_EA2);
      9:  step = mk_step(BC_RD_LO,   ACT_EA2);
      10: step = mk_step(BC_PUSH_LO, ACT_NONE);
      11: step = mk_step(BC_PUSH_HI, ACT_NONE);
      12: step = mk_step(BC_NOP,     ACT_NONE);
      13: step = mk_step(BC_IDLE,    ACT_NONE);
      14: step = mk_step(BC_POP_HI,  ACT_NONE);
      15: step = mk_step(BC_POP_LO,  ACT_NONE);
      16: step = mk_step(BC_WR_HI,   ACT_EA2);
      17: step = mk_step(BC_WR_LO,   ACT_NONE);
      18: step = mk_step(BC_NOP,     ACT_END);
      // acknowledge and fetch program
      20: step = mk_step(BC_IACK,    ACT_NONE);
      21: step = mk_step(BC_PFETCH,  ACT_ADVQ);
      22: step = mk_step(BC_PFETCH,  ACT_PC2);
      23: step = mk_step(BC_NOP,     ACT_END);
      // vector program
      24: step = mk_step(BC_VEC_HI,  ACT_EA2);
      25: step = mk_step(BC_VEC_LO,  ACT_NONE);
      26: step = mk_step(BC_NOP,     ACT_END);
      // wait-only program
      28: step = mk_step(BC_NOP,     ACT_NONE);
      29: step = mk_step(BC_IDLE,    ACT_NONE);
      30: step = mk_step(BC_RD_HI,   ACT_END);
      default: step = mk_step(BC_NOP, ACT_END);
    endcase
  end

endmodule

// File: rtl/bss_cycle_ctrl.sv
module bss_cycle_ctrl
  import bss_pkg::*;
#(
  parameter int unsigned AW        = 5,
  parameter int unsigned NOP_CLKS  = 4,
  parameter int unsigned IDLE_CLKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  step_t         step_i,
  input  logic          dtack_n_i,
  output logic [AW-1:0] ptr_o,
  output logic          req_o,
  output logic          cyc_done_o,
  output logic          done_o,
  output logic          busy_o,
  output logic          idle_o
);

  localparam int unsigned MAXW = (NOP_CLKS > IDLE_CLKS) ? NOP_CLKS : IDLE_CLKS;
  localparam int unsigned CW   = $clog2(MAXW) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_BOOT, ST_RUN} st_e;

  st_e           st_q, st_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ptr_en, cnt_en;
  logic          run, is_wait, is_end, wait_last;
  logic [CW-1:0] wait_lim;

  always_comb begin
    run       = (st_q == ST_RUN);
    is_end    = (step_i.act == ACT_END);
    is_wait   = code_is_wait(step_i.code);
    wait_lim  = (step_i.code == BC_NOP) ? CW'(NOP_CLKS - 1) : CW'(IDLE_CLKS - 1);
    wait_last = (cnt_q == wait_lim);

    req_o      = run && !is_end && !is_wait;
    cyc_done_o = run && !is_end && (is_wait ? wait_last : !dtack_n_i);
    done_o     = run && is_end;
    busy_o     = (st_q != ST_IDLE);
    idle_o     = (st_q == ST_IDLE);

    st_d   = st_q;
    ptr_d  = ptr_q;
    cnt_d  = cnt_q;
    ptr_en = 1'b0;
    cnt_en = 1'b0;

    case (st_q)
      ST_BOOT: begin
        st_d   = ST_RUN;
        ptr_d  = AW'(PRG_BOOT);
        ptr_en = 1'b1;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_RUN;
          ptr_d  = start_addr_i;
          ptr_en = 1'b1;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      ST_RUN: begin
        if (is_end) begin
          st_d = ST_IDLE;
        end else if (cyc_done_o) begin
          ptr_d  = ptr_q + 1'b1;
          ptr_en = 1'b1;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end else if (is_wait) begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_BOOT;
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (ptr_en) ptr_q <= ptr_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign ptr_o = ptr_q;

  a_r1_boot_enters_prog0: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BOOT) |=> (st_q == ST_RUN && ptr_q == AW'(PRG_BOOT)));

  a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && dtack_n_i) |=> (req_o && $stable(ptr_q)));

  a_r7_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < CW'(MAXW)));

  a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && !done_o));

endmodule

// File: rtl/bss_datapath.sv
module bss_datapath
  import bss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bus_code_e         code_i,
  input  step_act_e         act_i,
  input  logic              cyc_done_i,
  input  logic              idle_i,
  input  logic              sup_i,
  input  logic              ld_ea_i,
  input  logic              ld_dat_i,
  input  logic [DATA_W-1:0] ld_val_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic              upper_o,
  output logic              iack_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [DATA_W-1:0] bd_o,
  output logic [ADDR_W-1:0] usp_o,
  output logic [ADDR_W-1:0] ssp_o,
  output logic [WORD_W-1:0] pq0_o,
  output logic [WORD_W-1:0] pq1_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

  logic [ADDR_W-1:0] pc_q, pc_d, ea_q, ea_d, usp_q, usp_d, ssp_q, ssp_d, sp_cur;
  logic [DATA_W-1:0] bd_q, bd_d;
  logic [WORD_W-1:0] pq0_q, pq0_d, pq1_q, pq1_d;
  logic              is_push, is_pop, reg_en;

  // bus-side decode
  always_comb begin
    sp_cur  = sup_i ? ssp_q : usp_q;
    is_push = (code_i == BC_PUSH_HI) || (code_i == BC_PUSH_LO);
    is_pop  = (code_i == BC_POP_HI)  || (code_i == BC_POP_LO);
    upper_o = code_is_upper(code_i);
    we_o    = is_push || (code_i == BC_WR_HI) || (code_i == BC_WR_LO);
    iack_o  = (code_i == BC_IACK);
    if (code_i == BC_PFETCH) addr_o = pc_q;
    else if (is_push)        addr_o = sp_cur - STEP;
    else if (is_pop)         addr_o = sp_cur;
    else                     addr_o = ea_q;
    wdata_o = upper_o ? bd_q[DATA_W-1:WORD_W] : bd_q[WORD_W-1:0];
  end

  // next-state
  always_comb begin
    pc_d  = pc_q;
    ea_d  = ea_q;
    bd_d  = bd_q;
    usp_d = usp_q;
    ssp_d = ssp_q;
    pq0_d = pq0_q;
    pq1_d = pq1_q;

    if (cyc_done_i) begin
      case (code_i)
        BC_PFETCH: begin
          pq1_d = rdata_i;
          pc_d  = pc_q + STEP;
        end
        BC_RD_HI, BC_POP_HI:           bd_d[DATA_W-1:WORD_W] = rdata_i;
        BC_RD_LO, BC_POP_LO, BC_IACK:  bd_d[WORD_W-1:0]      = rdata_i;
        BC_VEC_HI: begin
          bd_d[DATA_W-1:WORD_W] = rdata_i;
          pc_d[ADDR_W-1:WORD_W] = rdata_i;
        end
        BC_VEC_LO: begin
          bd_d[WORD_W-1:0] = rdata_i;
          pc_d[WORD_W-1:0] = rdata_i;
        end
        BC_SSP_HI: ssp_d[ADDR_W-1:WORD_W] = rdata_i;
        BC_SSP_LO: ssp_d[WORD_W-1:0]      = rdata_i;
        default: ;
      endcase

      if (is_push || is_pop) begin
        if (sup_i) ssp_d = is_push ? ssp_q - STEP : ssp_q + STEP;
        else       usp_d = is_push ? usp_q - STEP : usp_q + STEP;
      end

      case (act_i)
        ACT_EA2:  ea_d  = ea_q + STEP;
        ACT_PC2:  pc_d  = pc_d + STEP;
        ACT_ADVQ: pq0_d = pq1_d;
        default: ;
      endcase
    end

    if (idle_i && ld_ea_i)  ea_d = ld_val_i;
    if (idle_i && ld_dat_i) bd_d = ld_val_i;

    reg_en = cyc_done_i || (idle_i && (ld_ea_i || ld_dat_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ea_q  <= '0;
      bd_q  <= '0;
      usp_q <= '0;
      ssp_q <= '0;
      pq0_q <= '0;
      pq1_q <= '0;
    end else if (reg_en) begin
      pc_q  <= pc_d;
      ea_q  <= ea_d;
      bd_q  <= bd_d;
      usp_q <= usp_d;
      ssp_q <= ssp_d;
      pq0_q <= pq0_d;
      pq1_q <= pq1_d;
    end
  end

  assign pc_o  = pc_q;
  assign ea_o  = ea_q;
  assign bd_o  = bd_q;
  assign usp_o = usp_q;
  assign ssp_o = ssp_q;
  assign pq0_o = pq0_q;
  assign pq1_o = pq1_q;

  // R5: a push lowers the pair of stack pointers by exactly one word in total
  a_r5_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done_i && is_push) |=> ((usp_q + ssp_q) == $past(usp_q + ssp_q) - STEP));

  a_r5_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done_i && is_pop) |=> ((usp_q + ssp_q) == $past(usp_q + ssp_q) + STEP));

  a_r6_fetch_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done_i && code_i == BC_PFETCH && act_i == ACT_NONE) |=> (pc_q == $past(pc_q) + STEP));

  a_r6_advance_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done_i && act_i == ACT_ADVQ) |=> (pq0_q == pq1_q));

endmodule

// File: rtl/bus_step_seq.sv
module bus_step_seq
  import bss_pkg::*;
#(
  parameter int unsigned ROM_AW    = 5,
  parameter int unsigned NOP_CLKS  = 4,
  parameter int unsigned IDLE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ROM_AW-1:0] start_addr,
  input  logic              supervisor,
  input  logic              ld_ea,
  input  logic              ld_dat,
  input  logic [31:0]       ld_val,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  output logic              mem_we,
  output logic              mem_upper,
  output logic              mem_iack,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              dtack_n,
  output logic              busy,
  output logic              done,
  output logic [31:0]       pc,
  output logic [31:0]       ea,
  output logic [31:0]       bus_data,
  output logic [31:0]       usp,
  output logic [31:0]       ssp,
  output logic [15:0]       pq0,
  output logic [15:0]       pq1
);

  logic              rst_sync_n;
  logic [ROM_AW-1:0] ptr;
  step_t             step;
  logic              cyc_done, idle;

  bss_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bss_step_rom #(.AW(ROM_AW)) u_rom (
    .addr (ptr),
    .step (step)
  );

  bss_cycle_ctrl #(
    .AW        (ROM_AW),
    .NOP_CLKS  (NOP_CLKS),
    .IDLE_CLKS (IDLE_CLKS)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start_i      (start),
    .start_addr_i (start_addr),
    .step_i       (step),
    .dtack_n_i    (dtack_n),
    .ptr_o        (ptr),
    .req_o        (mem_req),
    .cyc_done_o   (cyc_done),
    .done_o       (done),
    .busy_o       (busy),
    .idle_o       (idle)
  );

  bss_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .code_i     (step.code),
    .act_i      (step.act),
    .cyc_done_i (cyc_done),
    .idle_i     (idle),
    .sup_i      (supervisor),
    .ld_ea_i    (ld_ea),
    .ld_dat_i   (ld_dat),
    .ld_val_i   (ld_val),
    .rdata_i    (mem_rdata),
    .addr_o     (mem_addr),
    .we_o       (mem_we),
    .upper_o    (mem_upper),
    .iack_o     (mem_iack),
    .wdata_o    (mem_wdata),
    .pc_o       (pc),
    .ea_o       (ea),
    .bd_o       (bus_data),
    .usp_o      (usp),
    .ssp_o      (ssp),
    .pq0_o      (pq0),
    .pq1_o      (pq1)
  );

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && dtack_n) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_upper)));

  a_r8_no_req_on_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> !mem_req);

endmodule

// File: tb/sim_bus_step_seq.sv
`timescale 1ns/1ps
module sim_bus_step_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, supervisor, ld_ea, ld_dat, dtack_n;
  logic [4:0]  start_addr;
  logic [31:0] ld_val;
  logic [15:0] mem_rdata;
  logic        mem_req, mem_we, mem_upper, mem_iack, busy, done;
  logic [31:0] mem_addr, pc, ea, bus_data, usp, ssp;
  logic [15:0] mem_wdata, pq0, pq1;

  always #4 clk = ~clk;

  bus_step_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .supervisor(supervisor), .ld_ea(ld_ea), .ld_dat(ld_dat), .ld_val(ld_val),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we), .mem_upper(mem_upper),
    .mem_iack(mem_iack), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dtack_n(dtack_n),
    .busy(busy), .done(done), .pc(pc), .ea(ea), .bus_data(bus_data),
    .usp(usp), .ssp(ssp), .pq0(pq0), .pq1(pq1)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int lat = 0;

  logic [15:0] mem [256];
  int          li;
  logic [31:0] log_addr [64];
  logic        log_we   [64];
  logic        log_up   [64];
  logic        log_iack [64];
  logic [15:0] log_wd   [64];

  function automatic logic [15:0] init_word(int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0100;
      2: return 16'h0000;
      3: return 16'h0040;
      default: return 16'(k * 16'h0137 + 16'h2B05);
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: acknowledges after lat wait clocks
  initial begin
    int cnt;
    cnt = 0;
    dtack_n   = 1'b1;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        if (cnt == lat) begin
          cnt = 0;
          dtack_n = 1'b0;
          if (li < 64) begin
            log_addr[li] = mem_addr; log_we[li] = mem_we; log_up[li] = mem_upper;
            log_iack[li] = mem_iack; log_wd[li] = mem_wdata;
          end
          li++;
          if (mem_we) mem[mem_addr[8:1]] = mem_wdata;
          else        mem_rdata = mem[mem_addr[8:1]];
        end else begin
          cnt++;
          dtack_n = 1'b1;
        end
      end else begin
        cnt = 0;
        dtack_n = 1'b1;
      end
    end
  end

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      n++;
    end while (!done && n < 2000);
  endtask

  task automatic run_prog(int entry, output int n);
    @(negedge clk);
    li = 0;
    start_addr = 5'(entry);
    start = 1'b1;
    wait_done(n);
  endtask

  task automatic preload(logic [31:0] e, logic [31:0] d);
    @(negedge clk); ld_ea = 1'b1; ld_val = e;
    @(negedge clk); ld_ea = 1'b0; ld_dat = 1'b1; ld_val = d;
    @(negedge clk); ld_dat = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    logic [31:0] e, d, sp0, osp, pc0;
    logic [15:0] hi, lo;

    for (int k = 0; k < 256; k++) mem[k] = init_word(k);
    li = 0;
    rst_n = 1'b0; start = 0; start_addr = '0; supervisor = 0;
    ld_ea = 0; ld_dat = 0; ld_val = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset req", {31'd0, mem_req}, 32'd0);
    chk("R1 reset done", {31'd0, done}, 32'd0);
    chk("R1 reset pc", pc, 32'd0);
    chk("R1 reset ssp", ssp, 32'd0);
    rst_n = 1'b1;

    // R1 / R3 / R8: start-up program
    wait_done(n);
    chk("R1 ssp", ssp, 32'h0000_0100);
    chk("R1 pc", pc, 32'h0000_0044);
    chk("R1 pq0", {16'd0, pq0}, {16'd0, mem[8'h20]});
    chk("R1 pq1", {16'd0, pq1}, {16'd0, mem[8'h21]});
    chk("R1 ea", ea, 32'd6);
    chk("R1 bus_data", bus_data, 32'h0000_0040);
    chk("R8 boot cycles", li, 6);
    chk("R3 ssp hi addr", log_addr[0], 32'd0);
    chk("R3 ssp hi upper", {31'd0, log_up[0]}, 32'd1);
    chk("R3 ssp lo addr", log_addr[1], 32'd2);
    chk("R6 fetch addr", log_addr[4], 32'h40);
    chk("R6 fetch2 addr", log_addr[5], 32'h42);
    @(negedge clk);
    chk("R8 done pulse", {31'd0, done}, 32'd0);
    chk("R8 idle after", {31'd0, busy}, 32'd0);

    // R2 / R4 / R5: transfer program over latencies and both stacks
    for (int l = 0; l < 4; l++) begin
      lat = l;
      supervisor = l[0] ? 1'b0 : 1'b1;
      e = 32'h80 + 32'(l) * 32'h10;
      d = 32'hC0DE_0000 | 32'(l);
      preload(e, d);
      hi  = mem[e[8:1]];
      lo  = mem[e[8:1] + 8'd1];
      sp0 = supervisor ? ssp : usp;
      osp = supervisor ? usp : ssp;
      run_prog(PRG_XFER_E, n);
      chk("R2 clocks", n, 8 * (l + 1) + 7);
      chk("R2 cycles", li, 8);
      chk("R4 rd hi addr", log_addr[0], e);
      chk("R4 rd hi upper", {31'd0, log_up[0]}, 32'd1);
      chk("R4 rd lo addr", log_addr[1], e + 2);
      chk("R4 rd lo upper", {31'd0, log_up[1]}, 32'd0);
      chk("R5 push lo addr", log_addr[2], sp0 - 2);
      chk("R5 push lo data", {16'd0, log_wd[2]}, {16'd0, lo});
      chk("R5 push hi addr", log_addr[3], sp0 - 4);
      chk("R5 push hi we", {31'd0, log_we[3]}, 32'd1);
      chk("R5 pop hi addr", log_addr[4], sp0 - 4);
      chk("R5 pop lo addr", log_addr[5], sp0 - 2);
      chk("R4 wr hi addr", log_addr[6], e + 4);
      chk("R4 wr hi data", {16'd0, log_wd[6]}, {16'd0, hi});
      chk("R4 wr lo addr", log_addr[7], e + 6);
      chk("R4 wr lo data", {16'd0, log_wd[7]}, {16'd0, lo});
      chk("R4 bus_data", bus_data, {hi, lo});
      chk("R4 ea", ea, e + 6);
      chk("R5 sp restored", supervisor ? ssp : usp, sp0);
      chk("R5 other sp", supervisor ? usp : ssp, osp);
      chk("R4 mem written", {16'd0, mem[e[8:1] + 8'd2]}, {16'd0, hi});
    end

    // R6 / R9: acknowledge and fetch program
    lat = 1;
    preload(32'h60, 32'h5A5A_0000);
    pc0 = pc;
    run_prog(20, n);
    chk("R6 clocks", n, 3 * 2 + 1);
    chk("R9 iack addr", log_addr[0], 32'h60);
    chk("R9 iack flag", {31'd0, log_iack[0]}, 32'd1);
    chk("R9 iack off", {31'd0, log_iack[1]}, 32'd0);
    chk("R9 bus_data", bus_data, {16'h5A5A, mem[8'h30]});
    chk("R6 fetch addr", log_addr[1], pc0);
    chk("R6 fetch2 addr", log_addr[2], pc0 + 2);
    chk("R6 pq0", {16'd0, pq0}, {16'd0, mem[pc0[8:1]]});
    chk("R6 pq1", {16'd0, pq1}, {16'd0, mem[pc0[8:1] + 8'd1]});
    chk("R6 pc", pc, pc0 + 6);

    // R10: vector program
    lat = 0;
    preload(32'd4, 32'hFFFF_FFFF);
    run_prog(24, n);
    chk("R10 pc", pc, 32'h40);
    chk("R10 bus_data", bus_data, 32'h40);
    chk("R10 ea", ea, 32'd6);
    chk("R10 upper", {31'd0, log_up[0]}, 32'd1);

    // R7 / R8: wait-only program
    run_prog(28, n);
    chk("R7 clocks", n, 4 + 2 + 1);
    chk("R7 no request", li, 0);

    summary();
  end

  localparam int PRG_XFER_E = 8;

endmodule